// File: doc/BRIEF.md
# Coincidence Event Gating Unit

This block decides, once per pulse-processing event, whether that event is converted or thrown away. An external gate signal is compared with the portion of the event when the trapezoidal shaper is in its rise or flat-top phase. A single mode bit chooses how the gate is used. In coincidence mode a valid gate is required for the event to be kept. In anticoincidence mode a valid gate vetoes the event.

The gate input is asynchronous. It passes through a two-flop synchroniser, so every window comparison applies to the gate as it appeared two clock cycles earlier. A gate pulse is valid only after it has stayed high for a parameterised number of consecutive cycles (`GATE_MIN_CYC`, 5 by default). The bench clock is 125 MHz, where 5 cycles is 40 ns. At 100 MHz the same 5 cycles gives 50 ns, so `GATE_MIN_CYC` must be chosen for the target clock to meet a 50 ns minimum width. A pulse that rose before the shaper window opened still counts, provided it reaches the minimum width while the window is open. A per-event hit flag holds this result until the end-of-event strobe arrives.

The decision leaves the block as two single-cycle strobes, `accept` and `reject`. There is no buffering and no back-pressure. The consumer must capture the strobe in the cycle it appears. The shaper window, the end-of-event strobe and the mode bit are synchronous to `clk`.

Top module: `coinc_gate_unit`

## Requirements
- R1: `gate_in` is seen by the decision logic through exactly two clock stages. A gate level driven before clock edge k is treated as the synchronised gate in the cycle after edge k+1.
- R2: A synchronised gate pulse becomes qualified in its `GATE_MIN_CYC`-th consecutive high cycle and stays qualified while it remains high. A shorter pulse has no effect. Any low cycle restarts the width count, so two short pulses separated by a gap never add up.
- R3: An event records a hit only in a cycle where the qualified gate and `shaper_win` are both high. A pulse that started before the window counts if it is still high and qualified inside the window. A pulse that qualifies only after the window has closed does not count.
- R4: The hit flag is cleared in the cycle in which `shaper_win` rises, so an earlier event's hit never carries over.
- R5: Each cycle with `event_end` high is followed, in the next cycle only, by a one-cycle high on exactly one of `accept` and `reject`. Neither output is high in any other cycle.
- R6: With `anti_mode` = 0 (coincidence), the event is accepted when the hit flag is set and rejected otherwise.
- R7: With `anti_mode` = 1 (anticoincidence), the event is accepted when the hit flag is clear and rejected otherwise.
- R8: While `rst_n` is low, `accept` and `reject` are low, and the hit flag and the synchroniser are cleared. An event that ends after reset, with no gate, counts as having had no hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_in | input | 1 | External gate, asynchronous, active high |
| shaper_win | input | 1 | High while the shaper is in its rise or flat-top phase for the current event |
| event_end | input | 1 | One-cycle end-of-event strobe |
| anti_mode | input | 1 | 0 = coincidence (gate enables), 1 = anticoincidence (gate vetoes) |
| accept | output | 1 | One-cycle strobe: convert the event that just ended |
| reject | output | 1 | One-cycle strobe: discard the event that just ended |

## Verification
A hit flag stuck high or low inverts the decision on the next `event_end`. That error appears at the ports one cycle after the strobe. A width counter that fails to restart makes two split short pulses produce a hit. An off-by-one in the count threshold, or in the synchroniser depth, moves the qualification point by one cycle. That cycle decides whether a pulse placed at the window's closing edge is kept or dropped, so such errors surface on the next event whose gate sits on that boundary. A missing clear at the window's rising edge shows up as an accepted coincidence event that had no gate at all.

// File: rtl/cgu_pkg.sv
package cgu_pkg;

  typedef enum logic {
    MODE_COINC = 1'b0,
    MODE_ANTI  = 1'b1
  } gate_mode_e;

  typedef struct packed {
    logic accept;
    logic reject;
  } verdict_t;

endpackage

// File: rtl/cgu_sync.sv
module cgu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/cgu_width_qual.sv
module cgu_width_qual #(
  parameter int MIN_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic qualified
);

  localparam int CNT_W = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;
  localparam logic [CNT_W-1:0] SAT = CNT_W'(MIN_CYC - 1);

  logic [CNT_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (level) begin
      if (run_len != SAT) run_len <= run_len + 1'b1;
    end else begin
      run_len <= '0;
    end
  end

  assign qualified = level && (run_len == SAT);

endmodule

// File: rtl/cgu_event_judge.sv
module cgu_event_judge import cgu_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shaper_win,
  input  logic       gate_qual,
  input  logic       event_end,
  input  gate_mode_e mode,
  output verdict_t   verdict,
  output logic       hit_flag
);

  logic win_d;
  logic win_open;
  logic hit_next;
  logic keep;

  assign win_open = shaper_win && !win_d;
  assign hit_next = (win_open ? 1'b0 : hit_flag) | (shaper_win & gate_qual);

  always_comb begin
    unique case (mode)
      MODE_COINC: keep = hit_flag;
      MODE_ANTI:  keep = !hit_flag;
      default:    keep = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_d    <= 1'b0;
      hit_flag <= 1'b0;
      verdict  <= '0;
    end else begin
      win_d          <= shaper_win;
      hit_flag       <= hit_next;
      verdict.accept <= event_end && keep;
      verdict.reject <= event_end && !keep;
    end
  end

endmodule

// File: rtl/coinc_gate_unit.sv
module coinc_gate_unit import cgu_pkg::*; #(
  parameter int GATE_MIN_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  input  logic shaper_win,
  input  logic event_end,
  input  logic anti_mode,
  output logic accept,
  output logic reject
);

  localparam int SYNC_DEPTH = 2;

  logic       gate_sync;
  logic       gate_qual;
  logic       hit_flag;
  verdict_t   verdict;
  gate_mode_e mode;

  assign mode = gate_mode_e'(anti_mode);

  cgu_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (gate_in),
    .q_sync  (gate_sync)
  );

  cgu_width_qual #(.MIN_CYC(GATE_MIN_CYC)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (gate_sync),
    .qualified (gate_qual)
  );

  cgu_event_judge u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .shaper_win (shaper_win),
    .gate_qual  (gate_qual),
    .event_end  (event_end),
    .mode       (mode),
    .verdict    (verdict),
    .hit_flag   (hit_flag)
  );

  assign accept = verdict.accept;
  assign reject = verdict.reject;

endmodule

// File: rtl/coinc_gate_unit_checker.sv
module coinc_gate_unit_checker #(
  parameter int GATE_MIN_CYC = 5
) (
  input logic clk,
  input logic rst_n,
  input logic gate_in,
  input logic shaper_win,
  input logic event_end,
  input logic anti_mode,
  input logic accept,
  input logic reject,
  input logic gate_sync,
  input logic gate_qual,
  input logic hit_flag
);

  localparam int RUN_W = $clog2(GATE_MIN_CYC + 1) + 1;

  logic [1:0]       since_rst;
  logic [RUN_W-1:0] high_run;
  logic             win_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rst <= '0;
      high_run  <= '0;
      win_prev  <= 1'b0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      win_prev <= shaper_win;
      if (!gate_sync) high_run <= '0;
      else if (high_run < RUN_W'(GATE_MIN_CYC)) high_run <= high_run + 1'b1;
    end
  end

  // R1: two-stage synchroniser delay
  p_sync_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (gate_sync == $past(gate_in, 2)));

  // R2: qualification only after the minimum run of high cycles
  p_qual_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_qual |-> (high_run >= RUN_W'(GATE_MIN_CYC - 1)));

  p_qual_reached_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_sync && high_run >= RUN_W'(GATE_MIN_CYC - 1)) |-> gate_qual);

  // R3: outside the window the flag cannot change
  p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !shaper_win) |=> $stable(hit_flag));

  // R4: window rising edge without a qualified gate clears the flag
  p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shaper_win && !win_prev && !gate_qual) |=> !hit_flag);

  // R5: exclusive one-cycle verdict after each end strobe
  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && reject));

  p_verdict_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    event_end |=> (accept ^ reject));

  p_no_stray_verdict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && (accept || reject)) |-> $past(event_end));

  // R6: coincidence mode follows the flag
  p_coinc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (event_end && !anti_mode) |=> (accept == $past(hit_flag)));

  // R7: anticoincidence mode inverts the flag
  p_anti_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (event_end && anti_mode) |=> (accept == !$past(hit_flag)));

  // R8: outputs quiet in the first cycle out of reset
  p_reset_quiet_r8: assert property (@(posedge clk)
    (!rst_n) |=> (!accept && !reject && !hit_flag));

endmodule

bind coinc_gate_unit coinc_gate_unit_checker #(.GATE_MIN_CYC(GATE_MIN_CYC)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .gate_in    (gate_in),
  .shaper_win (shaper_win),
  .event_end  (event_end),
  .anti_mode  (anti_mode),
  .accept     (accept),
  .reject     (reject),
  .gate_sync  (gate_sync),
  .gate_qual  (gate_qual),
  .hit_flag   (hit_flag)
);

// File: tb/coinc_gate_unit_bench.sv
module coinc_gate_unit_bench;

  localparam int MIN_CYC = 5;
  localparam int NVEC    = 13;
  // Event frame: window high in cycles 10..29, end strobe in cycle 34.
  localparam int WIN_LO  = 10;
  localparam int WIN_HI  = 30;
  localparam int END_CYC = 34;
  localparam int FRAME   = 41;

  // mode, gate start, gate length, expected accept
  localparam int V_MODE [NVEC] = '{0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam int V_T0   [NVEC] = '{15,15,15,15, 2, 5, 6,31,24,23, 0, 0, 3};
  localparam int V_LEN  [NVEC] = '{ 6, 4, 6, 4, 5, 8, 3, 6, 5, 5, 0, 0,10};
  localparam int V_ACC  [NVEC] = '{ 1, 0, 0, 1, 0, 1, 0, 0, 0, 1, 0, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_in = 1'b0;
  logic shaper_win = 1'b0;
  logic event_end = 1'b0;
  logic anti_mode = 1'b0;
  logic accept;
  logic reject;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  coinc_gate_unit #(.GATE_MIN_CYC(MIN_CYC)) u_coinc_gate_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_in    (gate_in),
    .shaper_win (shaper_win),
    .event_end  (event_end),
    .anti_mode  (anti_mode),
    .accept     (accept),
    .reject     (reject)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One event frame with up to two gate pulses; checks the verdict.
  task automatic run_frame(input int mode, input int t0, input int len,
                           input int t1, input int len1, input logic exp_acc,
                           input string req, input logic win_en);
    for (int c = 0; c < FRAME; c++) begin
      @(negedge clk);
      if (c == END_CYC + 1) begin
        chk({req, " accept"}, accept, exp_acc);
        chk({req, " reject"}, reject, !exp_acc);
      end
      if (c == END_CYC + 2) chk("R5 strobe width", accept | reject, 1'b0);
      if (c == WIN_LO + 5)  chk("R5 quiet mid-event", accept | reject, 1'b0);
      anti_mode  = (mode != 0);
      shaper_win = win_en && (c >= WIN_LO) && (c < WIN_HI);
      gate_in    = ((c >= t0) && (c < t0 + len)) || ((c >= t1) && (c < t1 + len1));
      event_end  = (c == END_CYC);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 accept in reset", accept, 1'b0);
    chk("R8 reject in reset", reject, 1'b0);
    rst_n = 1'b1;

    // Vector table: R1 R2 R3 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      run_frame(V_MODE[v], V_T0[v], V_LEN[v], 0, 0, V_ACC[v] != 0,
                (V_MODE[v] != 0) ? "R7/R3/R2 vec" : "R6/R3/R2/R1 vec", 1'b1);
    end

    // R2: two short pulses with a one-cycle gap must not combine
    run_frame(0, 12, 3, 16, 3, 1'b0, "R2 split pulses", 1'b1);
    // R2: same span without the gap qualifies
    run_frame(0, 12, 7, 0, 0, 1'b1, "R2 joined pulse", 1'b1);
    // R4: hit left by an accepted event is cleared at the next window
    run_frame(0, 0, 0, 0, 0, 1'b0, "R4 flag cleared", 1'b1);
    // R3: gate with no window at all gives no hit (anticoincidence keeps it)
    run_frame(1, 15, 8, 0, 0, 1'b1, "R3 no window", 1'b0);

    // R8: reset between hit and end strobe clears the flag
    anti_mode  = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      shaper_win = (c >= 2) && (c < 16);
      gate_in    = (c >= 3) && (c < 12);
    end
    @(negedge clk);
    shaper_win = 1'b0;
    gate_in    = 1'b0;
    rst_n      = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 accept during reset", accept, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    event_end = 1'b1;
    @(negedge clk);
    event_end = 1'b0;
    chk("R8 flag cleared accept", accept, 1'b0);
    chk("R8 flag cleared reject", reject, 1'b1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule